// File: doc/BRIEF.md
# Address Translation Buffer with Store Protection

This block translates 32-bit virtual addresses into 32-bit physical addresses for a memory system that uses 4 KiB pages. It keeps a small set of translations in registers and compares every one of them against the page number of each incoming request at the same time. The low 12 address bits pass through unchanged. The upper 20 bits are replaced by the stored physical page number when a valid entry matches. Each request also says whether it is a load or a store. The block checks write permission in the same lookup, so a store to a page whose write-enable bit is clear is refused.

The block does not walk page tables or refill itself. A lookup with no matching valid entry returns a miss exception. A refused store returns a write-protection exception. Software then writes an entry through the install port, which takes a slot index and the full entry contents. A single-cycle flush input invalidates every slot.

Requests and responses use valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears one cycle later, registered. While a response is held because `rsp_ready` is low, `req_ready` is low as well, so no new request is accepted. The held response does not change until it is taken. With `rsp_ready` held high, one request is accepted every cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, every slot is invalid, `rsp_valid` is 0 and `req_ready` is 1. Any lookup made before an install returns a miss.
- R2: On a hit, `rsp_paddr` equals the matching slot's 20-bit physical page number in bits 31:12, with the request's bits 11:0 in bits 11:0.
- R3: A lookup with no valid slot whose tag equals virtual address bits 31:12 returns `rsp_miss_exc`=1 and `rsp_hit`=0. Its `rsp_paddr` is 0.
- R4: A store (`req_store`=1) that matches a slot whose write-enable bit is 0 returns `rsp_wprot_exc`=1 and `rsp_hit`=0, with `rsp_paddr`=0. A load to the same slot hits.
- R5: A store that matches a slot whose write-enable bit is 1 hits and delivers the translated address.
- R6: When `inst_en` is high on a clock edge, slot `inst_idx` is overwritten with the valid bit, write-enable bit, tag and page number given. Requests accepted on later edges see the new contents. Writing valid=0 removes the slot.
- R7: When `flush_all` is high on an edge, every slot becomes invalid on that edge. If an install happens on the same edge, the flush wins and the install is dropped.
- R8: When several valid slots match, the lowest-index slot supplies the page number and write-enable bit, and `rsp_multi_hit` is 1. Otherwise `rsp_multi_hit` is 0.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, all response outputs stay stable on the next cycle.
- R10: Every response has exactly one of `rsp_hit`, `rsp_miss_exc` and `rsp_wprot_exc` set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 unless hit) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss_exc | output | 1 | No valid matching slot |
| rsp_wprot_exc | output | 1 | Store to a write-disabled page |
| rsp_multi_hit | output | 1 | More than one slot matched (debug) |
| inst_en | input | 1 | Write a slot this cycle |
| inst_idx | input | 4 | Slot to write |
| inst_valid | input | 1 | Valid bit to write |
| inst_dirty | input | 1 | Write-enable bit to write |
| inst_vpn | input | 20 | Virtual page tag to write |
| inst_ppn | input | 20 | Physical page number to write |
| flush_all | input | 1 | Invalidate every slot |

## Verification
The hardest cases to reach are those where two mechanisms meet in one cycle. One is a flush and an install on the same edge. Another is a lookup that several slots match, combined with a store whose outcome depends on which slot wins. The bench drives `flush_all` and `inst_en` on the same negative edge, then looks up the installed tag and expects a miss. It installs the same tag into a higher and a lower slot, giving each a different write-enable bit and page number. A store then must raise the exception or succeed according to the lower slot only. Back-pressure is exercised by holding `rsp_ready` low across several cycles while requests wait. During that time the monitor checks that the response stays unchanged and that no request is accepted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VA_BITS   = 32;
  localparam int unsigned PA_BITS   = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned SLOTS     = 16;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_WPROT = 2'd2
  } res_kind_e;
endpackage

// File: rtl/xlat_slot_store.sv
module xlat_slot_store #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic             inst_valid,
  input  logic             inst_dirty,
  input  logic [VPN_W-1:0] inst_vpn,
  input  logic [PPN_W-1:0] inst_ppn,
  input  logic             flush_all,
  output logic [SLOTS-1:0] slot_valid,
  output logic [SLOTS-1:0] slot_dirty,
  output logic [VPN_W-1:0] slot_vpn [SLOTS],
  output logic [PPN_W-1:0] slot_ppn [SLOTS]
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic write_here;
    assign write_here = inst_en && !flush_all && (inst_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[i] <= 1'b0;
        slot_dirty[i] <= 1'b0;
        slot_vpn[i]   <= '0;
        slot_ppn[i]   <= '0;
      end else if (flush_all) begin
        slot_valid[i] <= 1'b0;
      end else if (write_here) begin
        slot_valid[i] <= inst_valid;
        slot_dirty[i] <= inst_dirty;
        slot_vpn[i]   <= inst_vpn;
        slot_ppn[i]   <= inst_ppn;
      end
    end
  end

  // R7: flush leaves no valid slot, even with a concurrent install
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (slot_valid == '0));

  // R6: an install lands in the addressed slot
  p_install_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_en && !flush_all) |=>
      (slot_valid[$past(inst_idx)] == $past(inst_valid)) &&
      (slot_ppn[$past(inst_idx)] == $past(inst_ppn)));

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [SLOTS-1:0] slot_valid,
  input  logic [VPN_W-1:0] slot_vpn [SLOTS],
  output logic             any_hit,
  output logic             multi_hit,
  output logic [IDX_W-1:0] hit_idx
);

  logic [SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = slot_valid[i] && (slot_vpn[i] == look_vpn);
  end

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = ($countones(hit_vec) > 1);

  // R8: the chosen slot matches and no lower slot does
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[hit_idx] &&
                 ((hit_vec & ((SLOTS'(1) << hit_idx) - SLOTS'(1))) == '0)));

  p_multi_implies_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> any_hit);

endmodule

// File: rtl/xlat_resp_stage.sv
module xlat_resp_stage
  import xlat_pkg::*;
#(
  parameter int unsigned PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  res_kind_e       in_kind,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_multi,
  output logic            out_valid,
  input  logic            out_ready,
  output res_kind_e       out_kind,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_multi
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= RES_MISS;
      out_paddr <= '0;
      out_multi <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind  <= in_kind;
        out_paddr <= in_paddr;
        out_multi <= in_multi;
      end
    end
  end

  // R9: a stalled response is held unchanged
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_kind) && $stable(out_paddr) && $stable(out_multi)));

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W   = VA_BITS,
  parameter int unsigned PA_W   = PA_BITS,
  parameter int unsigned PG_W   = PAGE_BITS,
  parameter int unsigned N_SLOT = SLOTS,
  localparam int unsigned VPN_W = VA_W - PG_W,
  localparam int unsigned PPN_W = PA_W - PG_W,
  localparam int unsigned IDX_W = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss_exc,
  output logic             rsp_wprot_exc,
  output logic             rsp_multi_hit,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic             inst_valid,
  input  logic             inst_dirty,
  input  logic [VPN_W-1:0] inst_vpn,
  input  logic [PPN_W-1:0] inst_ppn,
  input  logic             flush_all
);

  logic [N_SLOT-1:0] slot_valid;
  logic [N_SLOT-1:0] slot_dirty;
  logic [VPN_W-1:0]  slot_vpn [N_SLOT];
  logic [PPN_W-1:0]  slot_ppn [N_SLOT];

  logic              any_hit;
  logic              multi_hit;
  logic [IDX_W-1:0]  hit_idx;

  res_kind_e         look_kind;
  logic [PA_W-1:0]   look_paddr;
  res_kind_e         out_kind;

  xlat_slot_store #(
    .SLOTS(N_SLOT), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .inst_en    (inst_en),
    .inst_idx   (inst_idx),
    .inst_valid (inst_valid),
    .inst_dirty (inst_dirty),
    .inst_vpn   (inst_vpn),
    .inst_ppn   (inst_ppn),
    .flush_all  (flush_all),
    .slot_valid (slot_valid),
    .slot_dirty (slot_dirty),
    .slot_vpn   (slot_vpn),
    .slot_ppn   (slot_ppn)
  );

  xlat_match #(
    .SLOTS(N_SLOT), .VPN_W(VPN_W)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (req_vaddr[VA_W-1:PG_W]),
    .slot_valid (slot_valid),
    .slot_vpn   (slot_vpn),
    .any_hit    (any_hit),
    .multi_hit  (multi_hit),
    .hit_idx    (hit_idx)
  );

  // protection check and address assembly in the lookup cycle
  always_comb begin
    look_paddr = '0;
    if (!any_hit) begin
      look_kind = RES_MISS;
    end else if (req_store && !slot_dirty[hit_idx]) begin
      look_kind = RES_WPROT;
    end else begin
      look_kind  = RES_HIT;
      look_paddr = {slot_ppn[hit_idx], req_vaddr[PG_W-1:0]};
    end
  end

  xlat_resp_stage #(
    .PA_W(PA_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_kind   (look_kind),
    .in_paddr  (look_paddr),
    .in_multi  (multi_hit),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_kind  (out_kind),
    .out_paddr (rsp_paddr),
    .out_multi (rsp_multi_hit)
  );

  assign rsp_hit       = rsp_valid && (out_kind == RES_HIT);
  assign rsp_miss_exc  = rsp_valid && (out_kind == RES_MISS);
  assign rsp_wprot_exc = rsp_valid && (out_kind == RES_WPROT);

  // R10: exactly one outcome per response
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss_exc, rsp_wprot_exc}));

  // R3/R4: refused lookups carry no address
  p_no_addr_on_exc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss_exc || rsp_wprot_exc) |-> (rsp_paddr == '0));

  // R9: back-pressure reaches the request side
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2: a hit keeps the page offset of the accepted request
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (rsp_hit |-> (rsp_paddr[PG_W-1:0] == $past(req_vaddr[PG_W-1:0]))));

endmodule

// File: tb/xlat_buffer_tb.sv
module xlat_buffer_tb;
  timeunit 1ns; timeprecision 100ps;

  localparam int KIND_HIT = 0, KIND_MISS = 1, KIND_WPROT = 2;

  typedef struct {
    int          kind;
    logic [31:0] paddr;
    logic        multi;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_hit, rsp_miss_exc, rsp_wprot_exc, rsp_multi_hit;
  logic        inst_en = 1'b0;
  logic [3:0]  inst_idx = '0;
  logic        inst_valid = 1'b0, inst_dirty = 1'b0;
  logic [19:0] inst_vpn = '0, inst_ppn = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  xlat_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_miss_exc(rsp_miss_exc), .rsp_wprot_exc(rsp_wprot_exc),
    .rsp_multi_hit(rsp_multi_hit),
    .inst_en(inst_en), .inst_idx(inst_idx), .inst_valid(inst_valid),
    .inst_dirty(inst_dirty), .inst_vpn(inst_vpn), .inst_ppn(inst_ppn),
    .flush_all(flush_all)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic install(input int idx, input bit v, input bit d,
                         input logic [19:0] vpn, input logic [19:0] ppn,
                         input bit with_flush);
    @(negedge clk);
    inst_en = 1'b1; inst_idx = 4'(idx); inst_valid = v; inst_dirty = d;
    inst_vpn = vpn; inst_ppn = ppn; flush_all = with_flush;
    @(negedge clk);
    inst_en = 1'b0; flush_all = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  // driver: push expected item, then present the request until accepted
  task automatic lookup(input logic [31:0] va, input bit st, input int kind,
                        input logic [31:0] pa, input bit multi, input string req);
    exp_t e;
    e.kind = kind; e.paddr = pa; e.multi = multi; e.req = req;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(e);
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  // monitor: sample away from the edge, compare accepted responses
  logic        held = 1'b0;
  logic [31:0] held_pa;
  logic [2:0]  held_flags;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held) begin
          check(rsp_valid && rsp_paddr == held_pa &&
                {rsp_hit, rsp_miss_exc, rsp_wprot_exc} == held_flags,
                "R9", "held response changed", rsp_paddr, held_pa);
        end
        held = 1'b0;
        if (rsp_valid && !rsp_ready) begin
          check(!req_ready, "R9", "req_ready during stall", 32'(req_ready), 32'd0);
          held = 1'b1; held_pa = rsp_paddr;
          held_flags = {rsp_hit, rsp_miss_exc, rsp_wprot_exc};
        end
        if (rsp_valid && rsp_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R9", "unexpected response", rsp_paddr, 32'd0);
          end else begin
            exp_t e;
            logic [2:0] ef;
            e = sb.pop_front();
            ef = (e.kind == KIND_HIT)  ? 3'b100 :
                 (e.kind == KIND_MISS) ? 3'b010 : 3'b001;
            check({rsp_hit, rsp_miss_exc, rsp_wprot_exc} == ef, e.req,
                  "outcome hit/miss/wprot", 32'({rsp_hit, rsp_miss_exc, rsp_wprot_exc}),
                  32'(ef));
            check(rsp_paddr == e.paddr, e.req, "paddr", rsp_paddr, e.paddr);
            check(rsp_multi_hit == e.multi, e.req, "multi_hit",
                  32'(rsp_multi_hit), 32'(e.multi));
          end
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 50 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R9", "responses outstanding", 32'(sb.size()), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle after reset
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
    lookup(32'h0000_0000, 1'b0, KIND_MISS, 32'h0, 1'b0, "R1");
    lookup(32'hFFFF_FFFF, 1'b1, KIND_MISS, 32'h0, 1'b0, "R1");

    // R6 / R2: install and translate
    install(2, 1'b1, 1'b0, 20'h12345, 20'hABCDE, 1'b0);
    lookup(32'h1234_5678, 1'b0, KIND_HIT, 32'hABCD_E678, 1'b0, "R2");
    lookup(32'h1234_5FFF, 1'b0, KIND_HIT, 32'hABCD_EFFF, 1'b0, "R2");
    // R3: neighbour page misses
    lookup(32'h1234_6000, 1'b0, KIND_MISS, 32'h0, 1'b0, "R3");
    // R4: store to write-disabled page
    lookup(32'h1234_5010, 1'b1, KIND_WPROT, 32'h0, 1'b0, "R4");
    // R5 / R6: rewrite same slot with write enable
    install(2, 1'b1, 1'b1, 20'h12345, 20'h00077, 1'b0);
    lookup(32'h1234_5010, 1'b1, KIND_HIT, 32'h0007_7010, 1'b0, "R5");
    install(15, 1'b1, 1'b1, 20'hFFFFF, 20'h00001, 1'b0);
    lookup(32'hFFFF_F123, 1'b1, KIND_HIT, 32'h0000_1123, 1'b0, "R5");
    // R6: invalidating write removes slot
    install(15, 1'b0, 1'b1, 20'hFFFFF, 20'h00001, 1'b0);
    lookup(32'hFFFF_F123, 1'b0, KIND_MISS, 32'h0, 1'b0, "R6");

    // R8: duplicate tags in slots 9 and 3, lowest wins
    install(9, 1'b1, 1'b1, 20'h0BEEF, 20'h99999, 1'b0);
    lookup(32'h0BEE_F004, 1'b1, KIND_HIT, 32'h9999_9004, 1'b0, "R8");
    install(3, 1'b1, 1'b0, 20'h0BEEF, 20'h33333, 1'b0);
    lookup(32'h0BEE_F004, 1'b0, KIND_HIT, 32'h3333_3004, 1'b1, "R8");
    lookup(32'h0BEE_F004, 1'b1, KIND_WPROT, 32'h0, 1'b1, "R8");

    // R9: back-pressure with queued requests
    @(negedge clk);
    rsp_ready = 1'b0;
    fork
      begin
        lookup(32'h1234_5001, 1'b0, KIND_HIT, 32'h0007_7001, 1'b0, "R9");
        lookup(32'h5555_5000, 1'b0, KIND_MISS, 32'h0, 1'b0, "R9");
        lookup(32'h0BEE_F002, 1'b0, KIND_HIT, 32'h3333_3002, 1'b1, "R9");
      end
      begin
        repeat (5) @(negedge clk);
        rsp_ready = 1'b1;
        repeat (2) @(negedge clk);
        rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rsp_ready = 1'b1;
      end
    join
    drain();

    // R7: flush clears all; flush beats concurrent install
    do_flush();
    lookup(32'h1234_5001, 1'b0, KIND_MISS, 32'h0, 1'b0, "R7");
    lookup(32'h0BEE_F002, 1'b0, KIND_MISS, 32'h0, 1'b0, "R7");
    install(5, 1'b1, 1'b1, 20'h00042, 20'h00042, 1'b1);
    lookup(32'h0004_2000, 1'b0, KIND_MISS, 32'h0, 1'b0, "R7");
    // R10: all three outcomes seen back to back
    install(0, 1'b1, 1'b0, 20'h00042, 20'h00024, 1'b0);
    lookup(32'h0004_2ABC, 1'b0, KIND_HIT, 32'h0002_4ABC, 1'b0, "R10");
    lookup(32'h0004_2ABC, 1'b1, KIND_WPROT, 32'h0, 1'b0, "R10");
    lookup(32'h0004_3ABC, 1'b0, KIND_MISS, 32'h0, 1'b0, "R10");
    drain();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule